// File: doc/BRIEF.md
# Reed-Solomon Symbol Byte Corrector

This block applies the result of a Reed-Solomon decode to a flash page held in byte-wide storage. The code treats the 2048 main bytes and the spare bytes that follow them as one stream of 12-bit symbols, so two symbols share three bytes. The decoder delivers one (symbol position, 12-bit error value) pair at a time, and the last pair of a page is flagged. For each pair the block works out which one or two bytes the symbol covers and how its bits line up with them. It then reads each byte, XORs in the aligned slice of the error value and writes the byte back.

Storage is reached through a single synchronous byte port with one address space. Main byte n sits at address n and spare byte k sits at address 2048+k. Read data is valid in the cycle after a read strobe. When the flagged last pair has been handled, the block pulses an end-of-page strobe for one cycle. During that cycle it also presents whether the page could not be corrected and how many symbols were repaired. Pairs that arrive after the page has been judged uncorrectable are still taken but leave storage untouched.

Top module: `rs_sym_corrector`

## Requirements
- R1: For an odd position p, with b = floor(3p/2), address b is XORed with value bits 11..4 and address b+1 is XORed with value bits 3..0 placed in bits 7..4.
- R2: For an even non-zero position p, with b = floor(3p/2), address b-1 is XORed with value bits 11..8 placed in bits 3..0 and address b is XORed with value bits 7..0.
- R3: Position 0 touches only address 0, which is XORed with value bits 7..0. A value above 0xFF at position 0 marks the page uncorrectable and touches nothing.
- R4: Position 1365 puts value bits 11..4 into main byte 2047 (address 2047) and value bits 3..0, shifted to bits 7..4, into spare byte 0 (address 2048).
- R5: Positions 1366 to 1374 reach spare byte floor(3p/2)-2048 and its neighbour through addresses 2048 and up, using the odd or even rule.
- R6: A position above 1374 marks the page uncorrectable and causes no storage access. No access ever goes past address 2061.
- R7: At most 4 symbols are corrected per page. A fifth pair in the same page marks it uncorrectable and is not applied.
- R8: Once a page is uncorrectable, its later pairs are still accepted but are not applied and are not counted.
- R9: pageDone is high for exactly one cycle after the last pair of a page has finished. In that cycle pageFail and corrCount (the number of applied symbols) describe the page, and the next page then starts from a clear state.
- R10: Each byte is read and then rewritten before the next byte or pair is handled, so two symbols that share a byte both take effect. errReady is low for 4 cycles after an applied two-byte pair, 2 cycles after an applied position-0 pair and 0 cycles after a skipped pair, plus 1 more cycle when the pair is the last of its page.
- R11: After reset, errReady is high and pageDone, memRdEn and memWrEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | An error pair is offered |
| errReady | output | 1 | The block takes the offered pair |
| errPos | input | 11 | Symbol position |
| errPat | input | 12 | Error value to XOR in |
| errLast | input | 1 | Pair is the last of the page |
| memRdEn | output | 1 | Byte read strobe |
| memWrEn | output | 1 | Byte write strobe |
| memAddr | output | 12 | Byte address, spare bytes from 2048 |
| memWrData | output | 8 | Corrected byte |
| memRdData | input | 8 | Byte read data, valid one cycle after memRdEn |
| pageDone | output | 1 | End-of-page strobe |
| pageFail | output | 1 | Page uncorrectable, valid with pageDone |
| corrCount | output | 3 | Applied symbol count, valid with pageDone |

## Verification
A wrong alignment or offset in the mapping corrupts a byte next to the intended one. That error stays in storage and shows up when the page image is compared after its end strobe. A stuck or lost failure flag, or a counter that runs on, shows up as a wrong pageFail or corrCount on the very next end strobe. A skipped pair that still writes changes the image. A control state that is entered or left at the wrong time changes how long errReady stays low after the handshake, and the bench measures that length on every pair.

// File: rtl/rs_corr_pkg.sv
`timescale 1ns/1ps
package rs_corr_pkg;
  localparam int SYM_W = 12;

  typedef struct packed {
    logic load;     // capture the offered pair
    logic rdEn;     // read the selected byte
    logic wrEn;     // write the selected byte back
    logic selHi;    // select the second byte of the symbol
    logic endPage;  // clear the page state
  } corrStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_WR0, S_RD1, S_WR1, S_DONE
  } corrState_t;
endpackage

// File: rtl/rs_sym_map.sv
`timescale 1ns/1ps
module rs_sym_map #(
  parameter int POS_W  = 11,
  parameter int ADDR_W = 12
) (
  input  logic [POS_W-1:0]              pos,
  input  logic [rs_corr_pkg::SYM_W-1:0] pat,
  output logic [ADDR_W-1:0]             addrLo,
  output logic [7:0]                    maskLo,
  output logic [ADDR_W-1:0]             addrHi,
  output logic [7:0]                    maskHi,
  output logic                          twoBytes,
  output logic                          badFirst
);
  logic [POS_W+1:0] triple;
  logic [ADDR_W-1:0] base;

  always_comb begin
    triple   = {2'b00, pos} + {1'b0, pos, 1'b0};
    base     = ADDR_W'(triple >> 1);
    addrLo   = '0;
    maskLo   = '0;
    addrHi   = '0;
    maskHi   = '0;
    twoBytes = 1'b0;
    badFirst = 1'b0;
    if (pos == '0) begin
      // first symbol: its top nibble carries no data
      maskLo   = pat[7:0];
      badFirst = (pat[11:8] != 4'h0);
    end else if (pos[0]) begin
      addrLo   = base;
      maskLo   = pat[11:4];
      addrHi   = base + ADDR_W'(1);
      maskHi   = {pat[3:0], 4'h0};
      twoBytes = 1'b1;
    end else begin
      addrLo   = base - ADDR_W'(1);
      maskLo   = {4'h0, pat[11:8]};
      addrHi   = base;
      maskHi   = pat[7:0];
      twoBytes = 1'b1;
    end
  end
endmodule

// File: rtl/rs_corr_dp.sv
`timescale 1ns/1ps
module rs_corr_dp
  import rs_corr_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int ADDR_W  = 12,
  parameter int MAX_POS = 1374,
  parameter int MAX_ERR = 4,
  localparam int CNT_W  = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  corrStrobe_t       st,
  input  logic [POS_W-1:0]  errPos,
  input  logic [SYM_W-1:0]  errPat,
  input  logic [7:0]        memRdData,
  output logic              inSkip,
  output logic              inTwo,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              failOut,
  output logic [CNT_W-1:0]  cntOut
);
  localparam logic [POS_W-1:0]  MAX_POS_V = POS_W'(MAX_POS);
  localparam logic [CNT_W-1:0]  MAX_CNT_V = CNT_W'(MAX_ERR);
  localparam logic [ADDR_W-1:0] MAX_ADDR  = ADDR_W'((3 * MAX_POS) / 2);

  logic [ADDR_W-1:0] mAddrLo, mAddrHi, addrLoQ, addrHiQ;
  logic [7:0]        mMaskLo, mMaskHi, maskLoQ, maskHiQ;
  logic              mBadFirst, newFail, failQ;
  logic [CNT_W-1:0]  cntQ;

  rs_sym_map #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_map (
    .pos(errPos), .pat(errPat),
    .addrLo(mAddrLo), .maskLo(mMaskLo),
    .addrHi(mAddrHi), .maskHi(mMaskHi),
    .twoBytes(inTwo), .badFirst(mBadFirst)
  );

  assign newFail = (errPos > MAX_POS_V) | mBadFirst | (cntQ == MAX_CNT_V);
  assign inSkip  = failQ | newFail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
      maskLoQ <= '0;
      maskHiQ <= '0;
      failQ   <= 1'b0;
      cntQ    <= '0;
    end else if (st.endPage) begin
      failQ <= 1'b0;
      cntQ  <= '0;
    end else if (st.load) begin
      addrLoQ <= mAddrLo;
      addrHiQ <= mAddrHi;
      maskLoQ <= mMaskLo;
      maskHiQ <= mMaskHi;
      if (newFail)     failQ <= 1'b1;
      else if (!failQ) cntQ  <= cntQ + CNT_W'(1);
    end
  end

  assign memAddr   = st.selHi ? addrHiQ : addrLoQ;
  assign memWrData = memRdData ^ (st.selHi ? maskHiQ : maskLoQ);
  assign failOut   = failQ;
  assign cntOut    = cntQ;

  // R10
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrEn |-> ($past(st.rdEn) && memAddr == $past(memAddr)));
  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rdEn || st.wrEn) |-> memAddr <= MAX_ADDR);
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= MAX_CNT_V);
  // R8
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(failQ) && !$past(st.endPage)) |-> (cntQ == $past(cntQ) && failQ));
endmodule

// File: rtl/rs_corr_ctl.sv
`timescale 1ns/1ps
module rs_corr_ctl
  import rs_corr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        errValid,
  input  logic        errLast,
  input  logic        inSkip,
  input  logic        inTwo,
  output logic        errReady,
  output logic        pageDone,
  output corrStrobe_t st
);
  corrState_t state, nxt;
  logic lastQ, twoQ;

  always_comb begin
    st       = '0;
    errReady = 1'b0;
    pageDone = 1'b0;
    nxt      = state;
    unique case (state)
      S_IDLE: begin
        errReady = 1'b1;
        if (errValid) begin
          st.load = 1'b1;
          if (inSkip) nxt = errLast ? S_DONE : S_IDLE;
          else        nxt = S_RD0;
        end
      end
      S_RD0: begin
        st.rdEn = 1'b1;
        nxt     = S_WR0;
      end
      S_WR0: begin
        st.wrEn = 1'b1;
        if (twoQ)       nxt = S_RD1;
        else if (lastQ) nxt = S_DONE;
        else            nxt = S_IDLE;
      end
      S_RD1: begin
        st.rdEn  = 1'b1;
        st.selHi = 1'b1;
        nxt      = S_WR1;
      end
      S_WR1: begin
        st.wrEn  = 1'b1;
        st.selHi = 1'b1;
        nxt      = lastQ ? S_DONE : S_IDLE;
      end
      S_DONE: begin
        pageDone   = 1'b1;
        st.endPage = 1'b1;
        nxt        = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lastQ <= 1'b0;
      twoQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (st.load) begin
        lastQ <= errLast;
        twoQ  <= inTwo;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pageDone |=> (!pageDone && errReady));
  // R10
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && errReady && !inSkip) |=> (!errReady && st.rdEn));
endmodule

// File: rtl/rs_sym_corrector.sv
`timescale 1ns/1ps
module rs_sym_corrector
  import rs_corr_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int ADDR_W  = 12,
  parameter int MAX_POS = 1374,
  parameter int MAX_ERR = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           errValid,
  output logic                           errReady,
  input  logic [POS_W-1:0]               errPos,
  input  logic [SYM_W-1:0]               errPat,
  input  logic                           errLast,
  output logic                           memRdEn,
  output logic                           memWrEn,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [7:0]                     memWrData,
  input  logic [7:0]                     memRdData,
  output logic                           pageDone,
  output logic                           pageFail,
  output logic [$clog2(MAX_ERR+1)-1:0]   corrCount
);
  corrStrobe_t st;
  logic inSkip, inTwo;

  rs_corr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .errValid(errValid), .errLast(errLast),
    .inSkip(inSkip), .inTwo(inTwo), .errReady(errReady),
    .pageDone(pageDone), .st(st)
  );

  rs_corr_dp #(.POS_W(POS_W), .ADDR_W(ADDR_W), .MAX_POS(MAX_POS), .MAX_ERR(MAX_ERR)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .errPos(errPos), .errPat(errPat),
    .memRdData(memRdData), .inSkip(inSkip), .inTwo(inTwo),
    .memAddr(memAddr), .memWrData(memWrData),
    .failOut(pageFail), .cntOut(corrCount)
  );

  assign memRdEn = st.rdEn;
  assign memWrEn = st.wrEn;

  // R11
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRdEn && memWrEn));
endmodule

// File: tb/sim_rs_sym_corrector.sv
`timescale 1ns/1ps
module sim_rs_sym_corrector;
  localparam int MEM_BYTES = 2112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic errValid = 1'b0, errLast = 1'b0;
  logic [10:0] errPos = '0;
  logic [11:0] errPat = '0;
  logic errReady, memRdEn, memWrEn, pageDone, pageFail;
  logic [11:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic [2:0] corrCount;

  logic [7:0] mem  [0:MEM_BYTES-1];
  logic [7:0] refm [0:MEM_BYTES-1];
  int checks = 0, failures = 0, cycles = 0;
  int refCnt = 0;
  bit refFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rs_sym_corrector u0 (
    .clk(clk), .rst_n(rst_n), .errValid(errValid), .errReady(errReady),
    .errPos(errPos), .errPat(errPat), .errLast(errLast),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .pageDone(pageDone), .pageFail(pageFail), .corrCount(corrCount)
  );

  always @(posedge clk) begin
    if (memRdEn && int'(memAddr) < MEM_BYTES) memRdData <= mem[memAddr];
    if (memWrEn && int'(memAddr) < MEM_BYTES) mem[memAddr] <= memWrData;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic startPage(int seed);
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i]  = 8'(i * 37 + seed);
      refm[i] = 8'(i * 37 + seed);
    end
    refFail = 0;
    refCnt  = 0;
  endtask

  task automatic refXor(int off, int v);
    refm[off] = refm[off] ^ 8'(v);
  endtask

  // Expected effect from the requirements, in the unified byte space
  task automatic sendPair(int p, int pat, bit last, string req);
    bit skip;
    int b, expLow, expWr, lowCyc, wr, seen, f, c;
    skip = refFail || p > 1374 || (p == 0 && pat > 255) || refCnt == 4;
    if (!refFail && skip) refFail = 1;
    else if (!skip) refCnt++;
    if (!skip) begin
      b = (3 * p) / 2;
      if (p == 0) refXor(0, pat);
      else if (p % 2 == 1) begin refXor(b, pat >> 4); refXor(b + 1, (pat << 4) & 8'hF0); end
      else begin refXor(b - 1, pat >> 8); refXor(b, pat & 8'hFF); end
    end
    expWr  = skip ? 0 : (p == 0 ? 1 : 2);
    expLow = 2 * expWr + (last ? 1 : 0);
    @(negedge clk);
    errValid = 1'b1; errPos = 11'(p); errPat = 12'(pat); errLast = last;
    chk(errReady == 1'b1, "R10", "ready before pair", int'(errReady), 1);
    @(posedge clk);
    @(negedge clk);
    errValid = 1'b0;
    lowCyc = 0; wr = 0; seen = 0; f = 0; c = 0;
    while (!errReady && lowCyc < 20) begin
      lowCyc++;
      if (memWrEn) wr++;
      if (pageDone) begin seen++; f = int'(pageFail); c = int'(corrCount); end
      @(negedge clk);
    end
    chk(lowCyc == expLow, "R10", "busy cycles", lowCyc, expLow);
    chk(wr == expWr, req, "byte writes", wr, expWr);
    chk(seen == (last ? 1 : 0), "R9", "end strobes", seen, last ? 1 : 0);
    if (last) begin
      chk(f == int'(refFail), req, "pageFail", f, int'(refFail));
      chk(c == refCnt, req, "corrCount", c, refCnt);
    end
  endtask

  task automatic imageCheck(string req);
    int bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, req, "page image mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(errReady == 1'b1, "R11", "ready in reset", int'(errReady), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(errReady == 1'b1 && !pageDone, "R11", "ready/done after reset", int'({errReady, pageDone}), 2);
    chk(!memRdEn && !memWrEn, "R11", "idle memory port", int'({memRdEn, memWrEn}), 0);

    // R1 R2 R3 R4: one pair of each kind
    startPage(1);
    sendPair(5, 12'hABC, 0, "R1");
    sendPair(8, 12'h123, 0, "R2");
    sendPair(0, 12'h05A, 0, "R3");
    sendPair(1365, 12'hF0F, 1, "R4");
    imageCheck("R4");
    chk(mem[2047] == (8'(2047 * 37 + 1) ^ 8'hF0), "R4", "main byte 2047", int'(mem[2047]), int'(8'(2047 * 37 + 1) ^ 8'hF0));

    // R10: symbols 3 and 4 share byte 5; R5: last spare symbol
    startPage(2);
    sendPair(3, 12'h9C3, 0, "R10");
    sendPair(4, 12'h5A6, 0, "R10");
    sendPair(1374, 12'h777, 1, "R5");
    imageCheck("R10");
    chk(mem[5] == (8'(5 * 37 + 2) ^ 8'h35), "R10", "shared byte", int'(mem[5]), int'(8'(5 * 37 + 2) ^ 8'h35));

    // R3 R8: bad first symbol, later pairs consumed only
    startPage(3);
    sendPair(0, 12'h1FF, 0, "R3");
    sendPair(7, 12'h111, 0, "R8");
    sendPair(1366, 12'h222, 1, "R8");
    imageCheck("R8");

    // R6: out-of-range position
    startPage(4);
    sendPair(9, 12'h0F0, 0, "R2");
    sendPair(1375, 12'h333, 0, "R6");
    sendPair(2, 12'h444, 1, "R6");
    imageCheck("R6");

    // R7: fifth error in a page
    startPage(5);
    for (int k = 10; k < 14; k++) sendPair(k, 12'h101 * (k - 9), 0, "R7");
    sendPair(14, 12'hFFF, 1, "R7");
    imageCheck("R7");

    // R5: odd spare symbol, page state cleared since the failed page (R9)
    startPage(6);
    sendPair(1367, 12'hABC, 1, "R5");
    imageCheck("R5");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule